// File: doc/BRIEF.md
# SPI master transfer controller with DMA word buffer

This block is the word-level controller of an SPI master. Words to send can come from a core-written transmit register or from a four-entry word buffer that a DMA engine fills. Received words can go to a core-readable receive register or into the same buffer for a DMA engine to drain. A two-bit transfer mode chooses the source and sink. The mode also sets what starts each word, what the DMA request line means and which receive conditions are recorded. Once a mode is enabled, consecutive words follow each other with no idle serial-clock period, as long as the mode's start condition holds. No core action is needed between words.

The serial side uses clock-idle-low timing with the first phase capturing data, and sends the most significant bit first. The serial clock period is a fixed power of two of system clock cycles. The DMA side has two valid/ready streams. On the inbound stream a word is taken on a cycle where both valid and ready are high. Ready is high only in transmit-DMA mode while the buffer has room. On the outbound stream valid is high only in receive-DMA mode while the buffer holds a word. While valid is high and ready is low, the data is held unchanged. Control, status and interrupt pins are plain levels.

Top module: `spi_dma_master`

## Requirements
- R1: After reset, sclk and mosi are 0, busy, dma_req, err_irq, rx_full and rx_overrun are 0, and tx_empty is 1.
- R2: sclk is low when idle. Its period is 2^CLK_DIV_LOG2 clock cycles (4 by default) and it is gapless between consecutive words. mosi changes only while sclk is low, and miso is sampled on the rising sclk edge. Words are 16 bits with the MSB first.
- R3: Register writes use wr_addr 0 for control (bit0 enable, bits 2:1 mode, bit3 send-zero), wr_addr 1 for the transmit register and wr_addr 2 for status clear. In mode 2'b01 a transmit-register write starts a word that carries the written value. After that, words follow back to back until enable is cleared.
- R4: In mode 2'b01, a word that starts with no new transmit-register write since the last word is an underrun word. Its content is all zeros when send-zero is 1 and a repeat of the transmit register when send-zero is 0. An underrun never raises err_irq.
- R5: In mode 2'b11 a word starts only while the buffer holds a word, and the block stays idle while the buffer is empty. Buffered words go out in push order with no gap.
- R6: In mode 2'b11 received words are discarded. rx_data, rx_full and rx_overrun are left unchanged.
- R7: dma_req is 1 in mode 2'b10 while the buffer is not empty and in mode 2'b11 while the buffer is not full. It is 0 in the other modes and whenever enable is 0.
- R8: In mode 2'b10 words run continuously. Each received word is pushed into the buffer and appears on dma_out_data in arrival order.
- R9: In mode 2'b10, a word that completes while the buffer holds 4 words is dropped and rx_overrun is set. rx_overrun stays set until a write to wr_addr 2 with bit0 = 1. err_irq equals rx_overrun AND enable AND mode 2'b10.
- R10: In mode 2'b00 a word starts while rx_full is 0. A completed word is stored in rx_data and sets rx_full, and the block then stays idle. Pulsing rx_rd clears rx_full and lets the next word start. In modes 2'b00 and 2'b01, a word that completes while rx_full is 1 sets rx_overrun.
- R11: dma_in_ready is 0 while the buffer is full, so no word is taken. While dma_out_valid is 1 and dma_out_ready is 0, dma_out_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 transmit, 2 status clear |
| wr_data | input | 16 | Register write data |
| rx_rd | input | 1 | Core read pulse for the receive register; clears rx_full |
| rx_data | output | 16 | Receive register |
| rx_full | output | 1 | Receive register holds an unread word |
| tx_empty | output | 1 | No transmit-register write pending |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| busy | output | 1 | A word is being shifted |
| dma_req | output | 1 | DMA service request |
| err_irq | output | 1 | Error interrupt |
| dma_in_valid | input | 1 | Inbound DMA word valid |
| dma_in_ready | output | 1 | Inbound DMA word accepted |
| dma_in_data | input | 16 | Inbound DMA word |
| dma_out_valid | output | 1 | Outbound DMA word valid |
| dma_out_ready | input | 1 | Outbound DMA word taken |
| dma_out_data | output | 16 | Outbound DMA word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A register write takes effect at the clock edge that samples it. A word starts one edge later when its start condition holds. With the default divider the word finishes 64 cycles after its start edge, and rx_full, rx_overrun and buffer pushes update at that final edge. dma_req, dma_in_ready, dma_out_valid and err_irq are combinational from registered state, so they follow in the same cycle. The bench drives inputs just after an edge, samples outputs on falling clock edges, and polls status with bounded timeouts instead of fixed delays. The serial clock period and mosi stability are measured continuously against the R2 numbers.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;
  typedef enum logic [1:0] {
    XFER_RX_CORE = 2'b00,
    XFER_TX_CORE = 2'b01,
    XFER_RX_DMA  = 2'b10,
    XFER_TX_DMA  = 2'b11
  } xfer_mode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_TXREG = 2'd1;
  localparam logic [1:0] ADDR_CLEAR = 2'd2;
endpackage

// File: rtl/spi_dma_fifo.sv
module spi_dma_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  assign full  = (cnt == (AW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= wdata;
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty);
endmodule

// File: rtl/spi_dma_shifter.sv
module spi_dma_shifter #(
  parameter int DW           = 16,
  parameter int CLK_DIV_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int HALF = 2 ** (CLK_DIV_LOG2 - 1);
  localparam int CW   = (CLK_DIV_LOG2 > 1) ? CLK_DIV_LOG2 - 1 : 1;
  localparam int BW   = $clog2(DW);

  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          tick;

  assign tick    = busy && (cnt == CW'(HALF - 1));
  assign done    = tick && sclk && (bitn == BW'(DW - 1));
  assign rx_word = rx_sh;
  assign mosi    = busy ? tx_sh[DW-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; cnt <= '0; bitn <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (start && (!busy || done)) begin
      busy  <= 1'b1;
      sclk  <= 1'b0;
      cnt   <= '0;
      bitn  <= '0;
      tx_sh <= tx_word;
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[DW-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == BW'(DW - 1)) begin
            busy <= 1'b0;
          end else begin
            bitn  <= bitn + 1'b1;
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
endmodule

// File: rtl/spi_dma_master.sv
module spi_dma_master
  import spi_dma_pkg::*;
#(
  parameter int DW           = 16,
  parameter int FIFO_DEPTH   = 4,
  parameter int CLK_DIV_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          rx_overrun,
  output logic          busy,
  output logic          dma_req,
  output logic          err_irq,
  input  logic          dma_in_valid,
  output logic          dma_in_ready,
  input  logic [DW-1:0] dma_in_data,
  output logic          dma_out_valid,
  input  logic          dma_out_ready,
  output logic [DW-1:0] dma_out_data,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  logic          en, send_zero, tx_full;
  xfer_mode_e    mode;
  logic [DW-1:0] tx_reg;
  logic          sh_done, start, can_start, ovf_set, clr_wr, core_rx;
  logic [DW-1:0] sh_rx, start_word, f_wdata, f_rdata;
  logic          f_push, f_pop, f_full, f_empty;

  assign clr_wr  = wr_en && (wr_addr == ADDR_CLEAR) && wr_data[0];
  assign core_rx = (mode == XFER_RX_CORE) || (mode == XFER_TX_CORE);

  always_comb begin
    case (mode)
      XFER_RX_CORE: can_start = !rx_full && !sh_done;
      XFER_TX_CORE: can_start = tx_full || sh_done;
      XFER_RX_DMA:  can_start = 1'b1;
      default:      can_start = !f_empty;
    endcase
    case (mode)
      XFER_TX_DMA:  start_word = f_rdata;
      XFER_TX_CORE: start_word = (!tx_full && send_zero) ? '0 : tx_reg;
      default:      start_word = tx_reg;
    endcase
  end

  assign start   = en && can_start && (!busy || sh_done);
  assign ovf_set = sh_done && (((mode == XFER_RX_DMA) && f_full) ||
                               (core_rx && rx_full && !rx_rd));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mode <= XFER_RX_CORE; send_zero <= 1'b0;
      tx_reg <= '0; tx_full <= 1'b0;
      rx_data <= '0; rx_full <= 1'b0; rx_overrun <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == ADDR_CTRL)) begin
        en        <= wr_data[0];
        mode      <= xfer_mode_e'(wr_data[2:1]);
        send_zero <= wr_data[3];
      end
      if (wr_en && (wr_addr == ADDR_TXREG)) tx_reg <= wr_data;

      if (wr_en && (wr_addr == ADDR_TXREG))       tx_full <= 1'b1;
      else if (start && (mode == XFER_TX_CORE))   tx_full <= 1'b0;

      if (sh_done && core_rx) begin
        rx_data <= sh_rx;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end

      if (ovf_set)     rx_overrun <= 1'b1;
      else if (clr_wr) rx_overrun <= 1'b0;
    end
  end

  assign tx_empty      = !tx_full;
  assign dma_in_ready  = en && (mode == XFER_TX_DMA) && !f_full;
  assign dma_out_valid = en && (mode == XFER_RX_DMA) && !f_empty;
  assign dma_out_data  = f_rdata;
  assign dma_req       = dma_in_ready || dma_out_valid;
  assign err_irq       = rx_overrun && en && (mode == XFER_RX_DMA);

  assign f_push  = (dma_in_valid && dma_in_ready) ||
                   (sh_done && en && (mode == XFER_RX_DMA) && !f_full);
  assign f_wdata = (mode == XFER_TX_DMA) ? dma_in_data : sh_rx;
  assign f_pop   = (start && (mode == XFER_TX_DMA)) ||
                   (dma_out_valid && dma_out_ready);

  spi_dma_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en),
    .push(f_push), .wdata(f_wdata), .pop(f_pop), .rdata(f_rdata),
    .full(f_full), .empty(f_empty)
  );

  spi_dma_shifter #(.DW(DW), .CLK_DIV_LOG2(CLK_DIV_LOG2)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(start_word),
    .busy(busy), .done(sh_done), .rx_word(sh_rx),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !clr_wr) |=> rx_overrun);
  // R5
  txdma_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && (mode == XFER_TX_DMA)) |-> $past(!f_empty));
  // R6
  rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && (mode == XFER_TX_DMA)) |=> ($stable(rx_data) && !$rose(rx_overrun)));
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out_valid && !dma_out_ready) |=> (!dma_out_valid || $stable(dma_out_data)));
endmodule

// File: tb/test_spi_dma_master.sv
`timescale 1ns/1ps
module test_spi_dma_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rx_rd = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rx_data, dma_out_data;
  logic [15:0] dma_in_data = '0;
  logic        dma_in_valid = 1'b0, dma_out_ready = 1'b0;
  logic        rx_full, tx_empty, rx_overrun, busy, dma_req, err_irq;
  logic        dma_in_ready, dma_out_valid, sclk, mosi, miso;

  int checks = 0, errors = 0;
  always #10 clk = ~clk;

  spi_dma_master i_spi_dma_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .tx_empty(tx_empty),
    .rx_overrun(rx_overrun), .busy(busy), .dma_req(dma_req), .err_irq(err_irq),
    .dma_in_valid(dma_in_valid), .dma_in_ready(dma_in_ready), .dma_in_data(dma_in_data),
    .dma_out_valid(dma_out_valid), .dma_out_ready(dma_out_ready),
    .dma_out_data(dma_out_data), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // serial-side model: slave word source, mosi capture, sclk period monitor
  logic        tb_clr = 1'b0;
  logic [15:0] slv_seed = '0;
  int          slv_bit, slv_num, cap_b, cap_n;
  logic [15:0] cap_sh;
  logic [15:0] cap [0:15];
  realtime     t_last, pmin, pmax;
  logic [15:0] slv_word;
  assign slv_word = slv_seed + 16'(slv_num);
  assign miso = slv_word[4'(15 - slv_bit)];

  always @(posedge sclk or posedge tb_clr) begin
    if (tb_clr) begin
      slv_bit = 0; slv_num = 0; cap_b = 0; cap_n = 0; cap_sh = '0;
      t_last = 0; pmin = 1.0e9; pmax = 0;
    end else begin
      if (t_last != 0) begin
        if ($realtime - t_last < pmin) pmin = $realtime - t_last;
        if ($realtime - t_last > pmax) pmax = $realtime - t_last;
      end
      t_last = $realtime;
      cap_sh = {cap_sh[14:0], mosi};
      cap_b++;
      if (cap_b == 16) begin
        if (cap_n < 16) cap[cap_n] = cap_sh;
        cap_n++; cap_b = 0;
      end
      if (slv_bit == 15) begin slv_bit = 0; slv_num++; end
      else slv_bit++;
    end
  end

  int viol = 0;
  logic sclk_d = 1'b0, mosi_d = 1'b0;
  always @(negedge clk) begin
    if (sclk && sclk_d && (mosi !== mosi_d)) viol++;
    sclk_d = sclk; mosi_d = mosi;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ctrl(input logic en, input logic [1:0] m, input logic sz);
    reg_wr(2'd0, {12'd0, sz, m, en});
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic clear_model();
    @(negedge clk); tb_clr = 1'b1; @(negedge clk); tb_clr = 1'b0;
  endtask

  task automatic wait_caps(input int n);
    for (int i = 0; i < 5000 && cap_n < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_word(input logic [15:0] w);
    @(negedge clk); dma_in_valid = 1'b1; dma_in_data = w;
    while (!dma_in_ready) @(negedge clk);
    @(posedge clk); #1 dma_in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sclk", sclk, 0);        chk("R1 mosi", mosi, 0);
    chk("R1 busy", busy, 0);        chk("R1 dma_req", dma_req, 0);
    chk("R1 err_irq", err_irq, 0);  chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_overrun", rx_overrun, 0); chk("R1 tx_empty", tx_empty, 1);
  endtask

  task automatic t_tx_core();
    clear_model();
    ctrl(1'b1, 2'b01, 1'b0);
    reg_wr(2'd1, 16'hC3A5);
    wait_caps(3);
    chk("R3 first word", cap[0], 16'hC3A5);
    chk("R4 repeat fill 1", cap[1], 16'hC3A5);
    chk("R4 repeat fill 2", cap[2], 16'hC3A5);
    chk("R2 sclk period min", 32'(int'(pmin)), 80);
    chk("R2 sclk period max gapless", 32'(int'(pmax)), 80);
    chk("R4 no err_irq on underrun", err_irq, 0);
    ctrl(1'b0, 2'b01, 1'b0);
    wait_idle();
    chk("R10 overrun in core tx mode", rx_overrun, 1);
    chk("R9 err_irq off outside mode 10", err_irq, 0);
    clear_model();
    ctrl(1'b1, 2'b01, 1'b1);
    reg_wr(2'd1, 16'h1234);
    wait_caps(3);
    chk("R3 written word", cap[0], 16'h1234);
    chk("R4 zero fill 1", cap[1], 16'h0000);
    chk("R4 zero fill 2", cap[2], 16'h0000);
    ctrl(1'b0, 2'b01, 1'b1);
    wait_idle();
    chk("R3 stops when disabled", busy, 0);
    reg_wr(2'd2, 16'h0001);
    pulse_rd();
    chk("R9 overrun cleared", rx_overrun, 0);
    chk("R10 rx_full cleared", rx_full, 0);
  endtask

  task automatic t_tx_dma();
    logic [15:0] rx_keep;
    rx_keep = rx_data;
    clear_model();
    ctrl(1'b1, 2'b11, 1'b0);
    repeat (100) @(negedge clk);
    chk("R5 idle when buffer empty", busy, 0);
    chk("R5 nothing sent", 32'(cap_n), 0);
    chk("R7 req when not full", dma_req, 1);
    for (int i = 0; i < 5; i++) push_word(16'h1111 * 16'(i + 1));
    @(negedge clk);
    chk("R7 req low when full", dma_req, 0);
    chk("R11 ready low when full", dma_in_ready, 0);
    push_word(16'h6666);
    wait_caps(6);
    for (int i = 0; i < 6; i++) chk("R5 word order", cap[i], 16'h1111 * 16'(i + 1));
    chk("R5 gapless", 32'(int'(pmax)), 80);
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R5 idle after drain", busy, 0);
    chk("R6 rx_data kept", rx_data, rx_keep);
    chk("R6 rx_full kept", rx_full, 0);
    chk("R6 overrun kept", rx_overrun, 0);
    ctrl(1'b0, 2'b11, 1'b0);
  endtask

  task automatic t_rx_dma();
    clear_model();
    slv_seed = 16'h5A00;
    dma_out_ready = 1'b0;
    ctrl(1'b1, 2'b10, 1'b0);
    for (int i = 0; i < 1000 && !rx_overrun; i++) @(negedge clk);
    chk("R9 overrun on full buffer", rx_overrun, 1);
    chk("R9 err_irq in mode 10", err_irq, 1);
    chk("R7 req when not empty", dma_req, 1);
    repeat (10) @(negedge clk);
    chk("R11 head held", dma_out_data, 16'h5A00);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); dma_out_ready = 1'b1;
      chk("R8 receive order", dma_out_data, 16'h5A00 + 16'(i));
      @(posedge clk); #1 dma_out_ready = 1'b0;
    end
    for (int i = 0; i < 200 && !dma_out_valid; i++) @(negedge clk);
    chk("R9 overrun word dropped", dma_out_data, 16'h5A05);
    ctrl(1'b0, 2'b10, 1'b0);
    chk("R9 err_irq needs enable", err_irq, 0);
    chk("R9 overrun sticky", rx_overrun, 1);
    chk("R7 req low when disabled", dma_req, 0);
    wait_idle();
    reg_wr(2'd2, 16'h0001);
    chk("R9 cleared by write", rx_overrun, 0);
  endtask

  task automatic t_rx_core();
    clear_model();
    slv_seed = 16'h0F00;
    ctrl(1'b1, 2'b00, 1'b0);
    for (int i = 0; i < 500 && !rx_full; i++) @(negedge clk);
    chk("R10 first word stored", rx_data, 16'h0F00);
    chk("R10 rx_full set", rx_full, 1);
    repeat (150) @(negedge clk);
    chk("R10 idle while full", busy, 0);
    chk("R10 one word only", 32'(cap_n), 1);
    chk("R7 no req in mode 00", dma_req, 0);
    pulse_rd();
    for (int i = 0; i < 500 && !rx_full; i++) @(negedge clk);
    chk("R10 next word after read", rx_data, 16'h0F01);
    chk("R10 no overrun", rx_overrun, 0);
    ctrl(1'b0, 2'b00, 1'b0);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_core();
    t_tx_dma();
    t_rx_dma();
    t_rx_core();
    chk("R2 mosi stable while sclk high", 32'(viol), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule